// File: doc/BRIEF.md
# 8-bit ALU with Packed Status Flags

This block is the arithmetic and logic datapath of a small 8-bit processor core. Each cycle it combines two operands and a carry input under an operation select, and it returns an 8-bit result together with a packed status byte. The operations are add, add with carry, subtract, subtract with borrow, bitwise AND, OR and XOR, and a decimal-adjust step. The decimal adjust corrects the value on operand `a` after a packed-BCD add or subtract.

A status latch keeps the most recent flag byte. It loads on a rising clock edge only when `flag_we` is high. The decimal-adjust step reads the half-carry, subtract and carry bits from this latch, so the instruction that produced a BCD result must load its flags first. A 3-bit condition code selects one of the four testable flags and a polarity, and the block answers with a single branch-taken bit.

Top module: `alu8_core`

## Requirements
- R1: The flag byte is laid out with S at bit 7, Z at bit 6, H at bit 4, P/V at bit 2, N at bit 1 and C at bit 0. Bits 5 and 3 always read 0. The op encodings are ADD=0, ADC=1, SUB=2, SBC=3, AND=4, OR=5, XOR=6 and DADJ=7.
- R2: ADD returns the sum a+b, and ADC returns a+b+cin, each modulo 256. C is the carry out of bit 7.
- R3: SUB returns a-b, and SBC returns a-b-cin, each modulo 256. C is set when the operation borrows.
- R4: Z is 1 exactly when the 8-bit result is zero.
- R5: S equals bit 7 of the result.
- R6: For the four arithmetic ops, P/V is set when the signed two's-complement result falls outside -128..+127. For example, 0x78+0x69 sets P/V, while 0xFB+0xF0 sets C and leaves P/V clear.
- R7: For AND, OR and XOR, P/V is 1 when the result holds an even number of 1 bits and 0 when that number is odd.
- R8: For the arithmetic ops, H is the carry out of bit 3 on add, or the borrow out of bit 3 on subtract.
- R9: N is 1 after SUB and SBC, and 0 after ADD and ADC.
- R10: For AND, OR and XOR, C and N are 0. H is 1 for AND and 0 for OR and XOR.
- R11: DADJ forms a correction from the stored H, N and C bits. The correction includes 0x06 when H is set or the low nibble of a exceeds 9. It includes 0x60 when C is set or a exceeds 0x99. The correction is added when N=0 and subtracted when N=1. The new C is set when 0x60 was used. P/V takes the parity of the result. N is kept. The new H is (low nibble > 9) when N=0, or (old H and low nibble < 6) when N=1.
- R12: `flags_q` resets to 0x00. It takes `flags` on a rising edge where `flag_we` is 1, and it holds its value otherwise.
- R13: `cc[2:1]` selects a flag from `flags_q` (0=Z, 1=C, 2=P/V, 3=S). `taken` is 1 when that flag equals `cc[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a | input | 8 | First operand, also the value corrected by DADJ |
| b | input | 8 | Second operand |
| cin | input | 1 | Carry or borrow input for ADC and SBC |
| op | input | 3 | Operation select |
| flag_we | input | 1 | Load enable for the status latch |
| cc | input | 3 | Condition code: flag select and polarity |
| result | output | 8 | Operation result |
| flags | output | 8 | Packed flags of the current operation |
| flags_q | output | 8 | Latched flag byte |
| taken | output | 1 | Condition test on the latched flags |

## Verification
`result` and `flags` are combinational, so they are due in the same cycle as the operands. The bench drives inputs on a falling edge and samples these outputs one time step later. `flags_q` is due one rising edge after a cycle with `flag_we` high, and `taken` follows `flags_q` with no further delay. These two outputs are therefore sampled after the next rising edge, as are the decimal-adjust results, which depend on flags loaded one edge earlier. The hold checks drive `flag_we` low, present a different operation, and read `flags_q` after the next edge to confirm the value did not change.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DW = 8;
    localparam int NW = DW / 2;

    localparam int F_S  = 7;
    localparam int F_Z  = 6;
    localparam int F_H  = 4;
    localparam int F_PV = 2;
    localparam int F_N  = 1;
    localparam int F_C  = 0;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADC  = 3'd1,
        OP_SUB  = 3'd2,
        OP_SBC  = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_XOR  = 3'd6,
        OP_DADJ = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          s;
        logic          z;
        logic          h;
        logic          pv;
        logic          n;
        logic          c;
    } alu_out_t;

    function automatic logic [DW-1:0] pack_flags(alu_out_t o);
        logic [DW-1:0] f;
        f       = '0;
        f[F_S]  = o.s;
        f[F_Z]  = o.z;
        f[F_H]  = o.h;
        f[F_PV] = o.pv;
        f[F_N]  = o.n;
        f[F_C]  = o.c;
        return f;
    endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic          sub,
    output logic [DW-1:0] res,
    output logic          c_out,
    output logic          h_out,
    output logic          v_out
);
    logic [DW-1:0] bx;
    logic          ci;
    logic [DW:0]   full;
    logic [NW:0]   low;

    always_comb begin
        bx    = sub ? ~b : b;
        ci    = sub ? ~cin : cin;
        full  = {1'b0, a} + {1'b0, bx} + {{DW{1'b0}}, ci};
        low   = {1'b0, a[NW-1:0]} + {1'b0, bx[NW-1:0]} + {{NW{1'b0}}, ci};
        res   = full[DW-1:0];
        c_out = full[DW] ^ sub;
        h_out = low[NW] ^ sub;
        v_out = (a[DW-1] == bx[DW-1]) && (full[DW-1] != a[DW-1]);
    end
endmodule

// File: rtl/alu8_dadj.sv
module alu8_dadj
    import alu8_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic          h_in,
    input  logic          n_in,
    input  logic          c_in,
    output logic [DW-1:0] res,
    output logic          h_out,
    output logic          c_out
);
    logic [DW-1:0] corr;
    logic [NW-1:0] lo;
    logic          lo_big;

    always_comb begin
        lo     = a[NW-1:0];
        lo_big = lo > NW'(9);
        corr   = '0;
        c_out  = 1'b0;
        if (h_in || lo_big) corr[NW-1:0] = NW'(6);
        if (c_in || (a > DW'(8'h99))) begin
            corr[DW-1:NW] = NW'(6);
            c_out         = 1'b1;
        end
        res   = n_in ? (a - corr) : (a + corr);
        h_out = n_in ? (h_in && (lo < NW'(6))) : lo_big;
    end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
    import alu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] flags_in,
    input  logic [2:0]    cc,
    output logic [DW-1:0] flags_q,
    output logic          taken
);
    logic [DW-1:0] flags_d;
    logic          sel_bit;

    always_comb begin
        flags_d = we ? flags_in : flags_q;
        unique case (cc[2:1])
            2'd0:    sel_bit = flags_q[F_Z];
            2'd1:    sel_bit = flags_q[F_C];
            2'd2:    sel_bit = flags_q[F_PV];
            default: sel_bit = flags_q[F_S];
        endcase
        taken = (sel_bit == cc[0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(we) |-> $stable(flags_q));
    p_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(we) |-> (flags_q == $past(flags_in)));
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    a,
    input  logic [7:0]    b,
    input  logic          cin,
    input  logic [2:0]    op,
    input  logic          flag_we,
    input  logic [2:0]    cc,
    output logic [7:0]    result,
    output logic [7:0]    flags,
    output logic [7:0]    flags_q,
    output logic          taken
);
    alu_op_e       op_e;
    logic          is_sub, is_arith, is_logic, as_cin;
    logic [DW-1:0] as_res, da_res;
    logic          as_c, as_h, as_v, da_h, da_c;
    alu_out_t      out_d;

    assign op_e     = alu_op_e'(op);
    assign is_sub   = (op_e == OP_SUB) || (op_e == OP_SBC);
    assign is_arith = !op[2];
    assign is_logic = op[2] && (op_e != OP_DADJ);
    assign as_cin   = op[0] && cin;

    alu8_addsub u_addsub (
        .a(a), .b(b), .cin(as_cin), .sub(is_sub),
        .res(as_res), .c_out(as_c), .h_out(as_h), .v_out(as_v)
    );

    alu8_dadj u_dadj (
        .a(a), .h_in(flags_q[F_H]), .n_in(flags_q[F_N]), .c_in(flags_q[F_C]),
        .res(da_res), .h_out(da_h), .c_out(da_c)
    );

    always_comb begin
        out_d = '0;
        unique case (op_e)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                out_d.res = as_res;
                out_d.c   = as_c;
                out_d.h   = as_h;
                out_d.pv  = as_v;
                out_d.n   = is_sub;
            end
            OP_AND: begin
                out_d.res = a & b;
                out_d.h   = 1'b1;
            end
            OP_OR:  out_d.res = a | b;
            OP_XOR: out_d.res = a ^ b;
            default: begin
                out_d.res = da_res;
                out_d.c   = da_c;
                out_d.h   = da_h;
                out_d.n   = flags_q[F_N];
            end
        endcase
        if (!is_arith) out_d.pv = ~^out_d.res;
        out_d.s = out_d.res[DW-1];
        out_d.z = (out_d.res == '0);
        result  = out_d.res;
        flags   = pack_flags(out_d);
    end

    alu8_flagreg u_flagreg (
        .clk(clk), .rst_n(rst_n), .we(flag_we), .flags_in(flags),
        .cc(cc), .flags_q(flags_q), .taken(taken)
    );

    p_xbits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[5] == 1'b0) && (flags[3] == 1'b0));
    p_add_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_ADD) |-> ({flags[F_C], result} == ({1'b0, a} + {1'b0, b})));
    p_sub_borrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_SUB) |-> (flags[F_C] == (a < b)));
    p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flags[F_Z] == (result == 8'h00));
    p_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flags[F_S] == result[7]);
    p_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_ADD) |-> (flags[F_PV] == ((a[7] == b[7]) && (result[7] != a[7]))));
    p_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
        is_logic |-> (flags[F_PV] == ~^result));
    p_nflag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        is_arith |-> (flags[F_N] == op[1]));
    p_logic_r10: assert property (@(posedge clk) disable iff (!rst_n)
        is_logic |-> (!flags[F_C] && !flags[F_N]));
endmodule

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a = '0, b = '0;
    logic       cin = 1'b0;
    logic [2:0] op = '0;
    logic       flag_we = 1'b0;
    logic [2:0] cc = '0;
    logic [7:0] result, flags, flags_q;
    logic       taken;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    alu8_core u_dut (
        .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin), .op(op),
        .flag_we(flag_we), .cc(cc), .result(result), .flags(flags),
        .flags_q(flags_q), .taken(taken)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic comb_op(string tag, logic [2:0] o, logic [7:0] x, logic [7:0] y,
                           logic ci, logic [7:0] er, logic [7:0] ef);
        @(negedge clk);
        op = o; a = x; b = y; cin = ci; flag_we = 1'b0;
        #1;
        chk({tag, " result"}, result, er);
        chk({tag, " flags"}, flags, ef);
    endtask

    task automatic load_op(logic [2:0] o, logic [7:0] x, logic [7:0] y, logic ci);
        @(negedge clk);
        op = o; a = x; b = y; cin = ci; flag_we = 1'b1;
        @(negedge clk);
        flag_we = 1'b0;
    endtask

    task automatic t_reset;
        cc = 3'b000;
        #1;
        chk("R12 reset flags_q", flags_q, 8'h00);
        chk("R13 reset taken Z clear", {7'd0, taken}, 8'h01);
    endtask

    task automatic t_add;
        comb_op("R6 add overflow", 3'd0, 8'h78, 8'h69, 1'b0, 8'hE1, 8'h94);
        comb_op("R6 add neg no ovf carry", 3'd0, 8'hFB, 8'hF0, 1'b0, 8'hEB, 8'h81);
        comb_op("R2 R4 R8 adc wrap zero", 3'd1, 8'hFF, 8'h00, 1'b1, 8'h00, 8'h51);
        comb_op("R2 add ignores cin", 3'd0, 8'h01, 8'h02, 1'b1, 8'h03, 8'h00);
    endtask

    task automatic t_sub;
        comb_op("R3 R9 sub borrow", 3'd2, 8'h10, 8'h20, 1'b0, 8'hF0, 8'h83);
        comb_op("R3 R8 sbc borrow chain", 3'd3, 8'h00, 8'h00, 1'b1, 8'hFF, 8'h93);
        comb_op("R6 sub overflow", 3'd2, 8'h80, 8'h01, 1'b0, 8'h7F, 8'h16);
        comb_op("R4 sub zero", 3'd2, 8'h33, 8'h33, 1'b0, 8'h00, 8'h42);
    endtask

    task automatic t_logic;
        comb_op("R7 R10 and even", 3'd4, 8'hF0, 8'h3C, 1'b1, 8'h30, 8'h14);
        comb_op("R7 R4 xor zero", 3'd6, 8'hAA, 8'hAA, 1'b0, 8'h00, 8'h44);
        comb_op("R7 or even", 3'd5, 8'h01, 8'h02, 1'b0, 8'h03, 8'h04);
        comb_op("R7 or odd", 3'd5, 8'h01, 8'h00, 1'b0, 8'h01, 8'h00);
        comb_op("R5 R1 or sign", 3'd5, 8'h80, 8'h00, 1'b0, 8'h80, 8'h80);
    endtask

    task automatic t_dadj;
        load_op(3'd0, 8'h15, 8'h27, 1'b0);
        chk("R12 load after add", flags_q, 8'h00);
        comb_op("R11 dadj after add", 3'd7, 8'h3C, 8'h00, 1'b0, 8'h42, 8'h14);
        load_op(3'd2, 8'h42, 8'h15, 1'b0);
        chk("R12 load after sub", flags_q, 8'h12);
        comb_op("R11 dadj after sub", 3'd7, 8'h2D, 8'h00, 1'b0, 8'h27, 8'h06);
        load_op(3'd0, 8'h99, 8'h01, 1'b0);
        comb_op("R11 dadj decimal carry", 3'd7, 8'h9A, 8'h00, 1'b0, 8'h00, 8'h55);
    endtask

    task automatic t_latch_cond;
        load_op(3'd7, 8'h9A, 8'h00, 1'b0);
        chk("R12 load dadj flags", flags_q, 8'h55);
        @(negedge clk);
        op = 3'd5; a = 8'h80; b = 8'h00; flag_we = 1'b0;
        @(negedge clk);
        chk("R12 hold when disabled", flags_q, 8'h55);
        cc = 3'b001; #1; chk("R13 Z set", {7'd0, taken}, 8'h01);
        cc = 3'b000; #1; chk("R13 Z clear test", {7'd0, taken}, 8'h00);
        cc = 3'b011; #1; chk("R13 C set", {7'd0, taken}, 8'h01);
        cc = 3'b101; #1; chk("R13 PV set", {7'd0, taken}, 8'h01);
        cc = 3'b111; #1; chk("R13 S set", {7'd0, taken}, 8'h00);
        cc = 3'b110; #1; chk("R13 S clear", {7'd0, taken}, 8'h01);
    endtask

    initial begin
        t_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_add();
        t_sub();
        t_logic();
        t_dadj();
        t_latch_cond();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule